// File: doc/BRIEF.md
# Majority-clocked LFSR keystream generator

This block produces the per-frame keystream for a symmetric stream cipher on a frame-based radio link. It contains three shift registers of unequal length with linear feedback. A single start pulse begins a run. The block then clears the registers and feeds in a 64-bit session key one bit per cycle. It feeds in a 22-bit frame number the same way, and then steps the registers for 100 silent cycles under majority-vote clocking. After that it emits 228 keystream bits serially.

The first 114 output bits serve one link direction and the remaining 114 serve the other. A direction flag marks which half the current bit belongs to. An XOR stage combines each keystream bit with a data bit presented on the same cycle. The same stage encrypts and decrypts. A done pulse follows the last bit, and a new start can be accepted on that same cycle.

Top module: `maj_lfsr_ks`

## Requirements
- R1: After reset, busy_o, ks_valid_o, ks_o, ks_dir_o, ct_o and done_o are all 0.
- R2: A start_i pulse seen while busy_o is 0 clears all three registers, captures key_i and frame_i, and raises busy_o from the next cycle.
- R3: During loading, all three registers step on every cycle. The input bit is XORed into each register's feedback. The first 64 cycles use key bits and the next 22 cycles use frame bits, both taken least significant bit first.
- R4: The register lengths are 19, 22 and 23 bits. Their feedback taps are {18,17,16,13}, {21,20} and {22,21,20,7}. A step shifts the register left, puts the feedback into bit 0 and discards the old top bit.
- R5: After loading, the clocking bits are bit 8, bit 10 and bit 10 of the three registers. On each cycle, a register steps only if its clocking bit equals the majority value of the three clocking bits.
- R6: The block runs 100 majority steps with ks_valid_o low. The first valid bit therefore appears 187 cycles after the cycle in which start was accepted.
- R7: ks_valid_o is high for exactly 228 consecutive cycles per accepted start. On each of those cycles, ks_o is the XOR of the three registers' top bits, taken before that cycle's step. ks_o is 0 whenever ks_valid_o is 0.
- R8: ks_dir_o is 0 for output bits 0 to 113 and 1 for output bits 114 to 227.
- R9: While ks_valid_o is high, ct_o equals ks_o XOR pt_i. Otherwise ct_o is 0.
- R10: done_o is high for one cycle, on the cycle right after the last valid bit. busy_o is 0 on that cycle.
- R11: A start_i pulse seen while busy_o is 1 has no effect on the keystream being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a frame run when idle |
| key_i | input | 64 | Session key, captured on start |
| frame_i | input | 22 | Frame number, captured on start |
| pt_i | input | 1 | Data bit combined with the keystream |
| busy_o | output | 1 | Run in progress |
| ks_valid_o | output | 1 | Keystream bit valid |
| ks_o | output | 1 | Keystream bit |
| ks_dir_o | output | 1 | 0 for the first half of the frame, 1 for the second |
| ct_o | output | 1 | ks_o XOR pt_i while valid |
| done_o | output | 1 | One-cycle pulse after the last keystream bit |

## Verification
The assertions check the framing on every cycle. Valid must stay inside busy, and ks_o and ct_o must be quiet outside valid. The direction flag must start low and never drop back within a frame. Done must be a single pulse that arrives exactly when valid falls, after exactly 228 valid cycles. Every majority cycle must step at least two registers. The keystream values depend on the loading order, the taps and the clocking bits, so only the bench's scenarios can show them. The bench compares every bit against an independent model, and it also checks the 187-cycle latency and that a start issued mid-run is ignored.

// File: rtl/mlk_pkg.sv
package mlk_pkg;
  localparam int unsigned KEY_W_D = 64;
  localparam int unsigned FN_W_D  = 22;
  localparam int unsigned MIX_N_D = 100;
  localparam int unsigned KS_N_D  = 228;

  typedef enum logic [2:0] {
    PH_IDLE, PH_KEY, PH_FRM, PH_MIX, PH_OUT
  } phase_e;
endpackage

// File: rtl/mlk_lfsr.sv
module mlk_lfsr #(
  parameter int unsigned     LEN     = 19,
  parameter logic [LEN-1:0]  TAPS    = '0,
  parameter int unsigned     CLK_POS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic in_bit_i,
  output logic clk_bit_o,
  output logic msb_o
);
  logic [LEN-1:0] st_q;
  logic           fb;

  assign fb        = (^(st_q & TAPS)) ^ in_bit_i;
  assign clk_bit_o = st_q[CLK_POS];
  assign msb_o     = st_q[LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (clr_i)  st_q <= '0;
    else if (step_i) st_q <= {st_q[LEN-2:0], fb};
  end
endmodule

// File: rtl/mlk_maj.sv
module mlk_maj (
  input  logic [2:0] cbit_i,
  output logic [2:0] en_o
);
  logic maj;
  assign maj = (cbit_i[0] & cbit_i[1]) | (cbit_i[0] & cbit_i[2]) | (cbit_i[1] & cbit_i[2]);

  for (genvar i = 0; i < 3; i++) begin : g_en
    assign en_o[i] = (cbit_i[i] == maj);
  end
endmodule

// File: rtl/mlk_seq.sv
module mlk_seq
  import mlk_pkg::*;
#(
  parameter int unsigned KEY_W = KEY_W_D,
  parameter int unsigned FN_W  = FN_W_D,
  parameter int unsigned MIX_N = MIX_N_D,
  parameter int unsigned KS_N  = KS_N_D,
  parameter int unsigned CNT_W = $clog2(KEY_W + FN_W + MIX_N + KS_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [FN_W-1:0]  frame_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             in_bit_o,
  output logic             clr_o,
  output logic             done_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [KEY_W-1:0] key_q;
  logic [FN_W-1:0]  frm_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      key_q   <= '0;
      frm_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          key_q   <= key_i;
          frm_q   <= frame_i;
          cnt_q   <= '0;
          phase_q <= PH_KEY;
        end
        PH_KEY: begin
          key_q <= key_q >> 1;  // LSB first
          if (cnt_q == CNT_W'(KEY_W - 1)) begin
            cnt_q <= '0; phase_q <= PH_FRM;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_FRM: begin
          frm_q <= frm_q >> 1;
          if (cnt_q == CNT_W'(FN_W - 1)) begin
            cnt_q <= '0; phase_q <= PH_MIX;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_MIX: begin
          if (cnt_q == CNT_W'(MIX_N - 1)) begin
            cnt_q <= '0; phase_q <= PH_OUT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_OUT: begin
          if (cnt_q == CNT_W'(KS_N - 1)) begin
            cnt_q <= '0; phase_q <= PH_IDLE; done_q <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign cnt_o    = cnt_q;
  assign clr_o    = (phase_q == PH_IDLE) && start_i;
  assign in_bit_o = (phase_q == PH_KEY) ? key_q[0] :
                    (phase_q == PH_FRM) ? frm_q[0] : 1'b0;
  assign done_o   = done_q;
endmodule

// File: rtl/maj_lfsr_ks.sv
module maj_lfsr_ks
  import mlk_pkg::*;
#(
  parameter int unsigned KEY_W = KEY_W_D,
  parameter int unsigned FN_W  = FN_W_D,
  parameter int unsigned MIX_N = MIX_N_D,
  parameter int unsigned KS_N  = KS_N_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [FN_W-1:0]  frame_i,
  input  logic             pt_i,
  output logic             busy_o,
  output logic             ks_valid_o,
  output logic             ks_o,
  output logic             ks_dir_o,
  output logic             ct_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(KEY_W + FN_W + MIX_N + KS_N);
  localparam int unsigned HALF  = KS_N / 2;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             in_bit, clr;
  logic             load_ph, maj_ph;
  logic [2:0]       cbit, msb, maj_en, step_en;
  logic             ks_raw;

  mlk_seq #(.KEY_W(KEY_W), .FN_W(FN_W), .MIX_N(MIX_N), .KS_N(KS_N), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .key_i, .frame_i,
    .phase_o(phase), .cnt_o(cnt), .in_bit_o(in_bit), .clr_o(clr), .done_o(done_o)
  );

  assign load_ph = (phase == PH_KEY) || (phase == PH_FRM);
  assign maj_ph  = (phase == PH_MIX) || (phase == PH_OUT);
  assign step_en = {3{load_ph}} | ({3{maj_ph}} & maj_en);

  mlk_lfsr #(.LEN(19), .TAPS(19'h72000), .CLK_POS(8)) u_r0 (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step_en[0]), .in_bit_i(in_bit),
    .clk_bit_o(cbit[0]), .msb_o(msb[0]));
  mlk_lfsr #(.LEN(22), .TAPS(22'h300000), .CLK_POS(10)) u_r1 (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step_en[1]), .in_bit_i(in_bit),
    .clk_bit_o(cbit[1]), .msb_o(msb[1]));
  mlk_lfsr #(.LEN(23), .TAPS(23'h700080), .CLK_POS(10)) u_r2 (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step_en[2]), .in_bit_i(in_bit),
    .clk_bit_o(cbit[2]), .msb_o(msb[2]));

  mlk_maj u_maj (.cbit_i(cbit), .en_o(maj_en));

  assign ks_raw     = ^msb;
  assign busy_o     = (phase != PH_IDLE);
  assign ks_valid_o = (phase == PH_OUT);
  assign ks_o       = ks_valid_o & ks_raw;
  assign ks_dir_o   = ks_valid_o && (cnt >= CNT_W'(HALF));
  assign ct_o       = ks_valid_o & (ks_raw ^ pt_i);
endmodule

// File: rtl/mlk_chk.sv
module mlk_chk #(
  parameter int unsigned KS_N = 228
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       ks_valid_o,
  input logic       ks_o,
  input logic       ks_dir_o,
  input logic       ct_o,
  input logic       done_o,
  input logic       maj_ph,
  input logic [2:0] step_en
);
  localparam int unsigned VW = $clog2(KS_N + 1);
  logic [VW-1:0] vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         vcnt_q <= '0;
    else if (done_o)     vcnt_q <= '0;
    else if (ks_valid_o) vcnt_q <= vcnt_q + 1'b1;
  end

  // R2
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R5
  maj_two_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    maj_ph |-> $countones(step_en) >= 2);
  // R7
  valid_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o |-> busy_o);
  // R7
  ks_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ks_valid_o |-> !ks_o);
  // R7
  valid_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> vcnt_q == VW'(KS_N));
  // R8
  dir_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ks_valid_o) |-> !ks_dir_o);
  // R8
  dir_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o && $past(ks_dir_o) |-> ks_dir_o);
  // R9
  ct_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ks_valid_o |-> !ct_o);
  // R10
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ks_valid_o) |-> done_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind maj_lfsr_ks mlk_chk #(.KS_N(KS_N)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .ks_valid_o(ks_valid_o), .ks_o(ks_o), .ks_dir_o(ks_dir_o), .ct_o(ct_o),
  .done_o(done_o), .maj_ph(maj_ph), .step_en(step_en)
);

// File: tb/maj_lfsr_ks_tb_top.sv
`timescale 1ns/1ps
module maj_lfsr_ks_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] key_i = '0;
  logic [21:0] frame_i = '0;
  logic        pt_i = 1'b0;
  logic        busy_o, ks_valid_o, ks_o, ks_dir_o, ct_o, done_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  always #5 clk_i = ~clk_i;

  maj_lfsr_ks dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // independent keystream model built from R3, R4, R5, R7
  function automatic logic [227:0] model(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a = '0;
    logic [21:0] b = '0;
    logic [22:0] c = '0;
    logic [227:0] ks = '0;
    logic in, m;
    for (int i = 0; i < 86; i++) begin
      in = (i < 64) ? k[i] : f[i-64];
      a = {a[17:0], a[18]^a[17]^a[16]^a[13]^in};
      b = {b[20:0], b[21]^b[20]^in};
      c = {c[21:0], c[22]^c[21]^c[20]^c[7]^in};
    end
    for (int i = 0; i < 328; i++) begin
      if (i >= 100) ks[i-100] = a[18] ^ b[21] ^ c[22];
      m = (a[8]&b[10]) | (a[8]&c[10]) | (b[10]&c[10]);
      if (a[8] == m)  a = {a[17:0], a[18]^a[17]^a[16]^a[13]};
      if (b[10] == m) b = {b[20:0], b[21]^b[20]};
      if (c[10] == m) c = {c[21:0], c[22]^c[21]^c[20]^c[7]};
    end
    return ks;
  endfunction

  task automatic run_frame(input logic [63:0] k, input logic [21:0] f, input bit poke);
    logic [227:0] exp = model(k, f);
    int n = 0;
    @(negedge clk_i);
    start_i = 1'b1; key_i = k; frame_i = f;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 1;
    #1 check("R2 busy after start", busy_o, 1'b1);
    while (!ks_valid_o && n < 400) begin
      @(negedge clk_i);
      n++;
      if (poke && n == 50) begin start_i = 1'b1; key_i = ~k; frame_i = ~f; end  // R11
      else start_i = 1'b0;
      #1;
    end
    check("R6 first valid latency", n, 187);
    for (int i = 0; i < 228; i++) begin
      if (i > 0) begin
        @(negedge clk_i);
        pt_i = 1'($urandom);
        #1;
      end else begin
        pt_i = 1'($urandom);
        #1;
      end
      check(poke ? "R11 ks after busy start" : "R3 R4 R5 R7 ks bit", ks_o, exp[i]);
      check("R7 valid", ks_valid_o, 1'b1);
      check("R8 dir", ks_dir_o, (i >= 114));
      check("R9 ct", ct_o, exp[i] ^ pt_i);
      check("R10 no early done", done_o, 1'b0);
    end
    @(negedge clk_i); #1;
    check("R7 valid ends", ks_valid_o, 1'b0);
    check("R10 done", done_o, 1'b1);
    check("R10 idle at done", busy_o, 1'b0);
    check("R9 ct quiet", ct_o, 1'b0);
    @(negedge clk_i); #1;
    check("R10 done one cycle", done_o, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 busy", busy_o, 1'b0);
    check("R1 valid", ks_valid_o, 1'b0);
    check("R1 ks", ks_o, 1'b0);
    check("R1 ct", ct_o, 1'b0);
    check("R1 done", done_o, 1'b0);
    check("R1 dir", ks_dir_o, 1'b0);
    rst_ni = 1'b1;
    run_frame(64'h0, 22'h0, 1'b0);
    run_frame('1, 22'h3fffff, 1'b0);
    run_frame(64'h1, 22'h0, 1'b0);
    run_frame(64'h0, 22'h200000, 1'b0);
    run_frame(64'h0123456789abcdef, 22'h134, 1'b1);
    for (int r = 0; r < 6; r++) begin
      logic [63:0] k = {$urandom, $urandom};
      run_frame(k, 22'($urandom), r[0]);
      run_frame(k, 22'($urandom), 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule